// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns writes to a software-interrupt request word into pending state for the processors in a cluster. Each write names one of the software interrupts, a target set, and the processor that made the write. The target set can be an explicit list, every processor except the writer, or the writer alone. The block sets one pending bit for each enabled processor in that set. Pending state is held per interrupt as a matrix indexed by sender and target. Acknowledge logic can later tell who raised an interrupt and retire exactly that one bit.

Request writes enter through a valid/ready port. The dispatcher applies a write in the cycle it is accepted and never pushes back, so `wr_ready` is high whenever reset is released. A write is accepted on a clock edge where both `wr_valid` and `wr_ready` are high. The clear port and the per-processor enable vector are plain control inputs. The full pending matrix is a registered output and is valid one cycle after the write or clear that changed it.

Top module: `sgi_dispatch`

## Requirements
- R1: A write is taken only on an edge where `wr_valid` and `wr_ready` are both high. In the request word, bits 3:0 give the interrupt number, bits 23:16 give the target list with bit n for processor n, and bits 25:24 give the filter. All other bits are ignored.
- R2: Filter 0 uses the target list from the request word as the target set.
- R3: Filter 1 targets every processor except the sender, and the target list is ignored.
- R4: Filter 2 targets only the sender, and the target list is ignored.
- R5: Filter 3 is reserved. A write with filter 3 changes no pending bit.
- R6: A target whose bit in `cpu_en` is low gets no pending bit from the write.
- R7: A set goes to `pend_o` bit sgi*64 + sender*8 + target on the edge that takes the write. Pending bits accumulate across writes and stay set until they are cleared.
- R8: When `clr_valid` is high, the single bit at clr_sgi*64 + clr_sender*8 + clr_target is cleared on that edge. All other bits keep their value.
- R9: If a set and a clear hit the same bit on the same edge, the bit ends up set.
- R10: Reset clears every pending bit. `wr_ready` is high whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Request word is present |
| wr_ready | output | 1 | Dispatcher accepts a request (no back-pressure) |
| wr_sender | input | 3 | Processor that made the write |
| wr_data | input | 32 | Request word |
| cpu_en | input | 8 | Per-processor interface enable |
| clr_valid | input | 1 | Clear one pending bit |
| clr_sgi | input | 4 | Interrupt number of the bit to clear |
| clr_sender | input | 3 | Sender index of the bit to clear |
| clr_target | input | 3 | Target index of the bit to clear |
| pend_o | output | 1024 | Pending matrix; bit sgi*64 + sender*8 + target |

## Verification
The table-driven stimulus exercises each filter with different senders, interrupt numbers, lists and enable masks. Each run starts from a fresh reset, so a wrong shift distance, a swapped sender and target, or a wrong interrupt slot shows up as a bad row. Enable masks with holes tell a correct enable gate from a missing one, and a word with ones in every unused field checks that only the three fields are decoded. Directed sequences then write from two senders into the same interrupt to check that bits accumulate. They clear a single bit, and they collide a set with a clear on the same bit to check that the set wins.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_FLD_LSB = 0;
  localparam int TGT_FLD_LSB = 16;
  localparam int FLT_FLD_LSB = 24;
  localparam int FLT_W       = 2;

  typedef enum logic [FLT_W-1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } sgi_filter_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int WORD_W  = 32,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int SGI_W  = $clog2(NUM_SGI),
  localparam int ROW_W  = NUM_CPU * NUM_CPU,
  localparam int PEND_W = NUM_SGI * ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CPU_W-1:0]  sender,
  input  logic [WORD_W-1:0] data,
  input  logic [NUM_CPU-1:0] cpu_en,
  output logic [PEND_W-1:0] set_vec
);
  sgi_filter_e        filt;
  logic [NUM_CPU-1:0] list, self_oh, tgt, tgt_en;
  logic [SGI_W-1:0]   sgi;
  logic [ROW_W-1:0]   row;

  assign filt    = sgi_filter_e'(data[FLT_FLD_LSB +: FLT_W]);
  assign list    = data[TGT_FLD_LSB +: NUM_CPU];
  assign sgi     = data[SGI_FLD_LSB +: SGI_W];
  assign self_oh = NUM_CPU'(1) << sender;

  always_comb begin
    case (filt)
      FLT_LIST:   tgt = list;
      FLT_OTHERS: tgt = ~self_oh;
      FLT_SELF:   tgt = self_oh;
      default:    tgt = '0;
    endcase
  end

  assign tgt_en = tgt & cpu_en;
  assign row    = ROW_W'(tgt_en) << (sender * NUM_CPU);

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_slot
    assign set_vec[g*ROW_W +: ROW_W] = (fire && sgi == SGI_W'(g)) ? row : '0;
  end

  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && filt == FLT_SELF) |-> $countones(set_vec) <= 1);  // R4
  AST_RSVD_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (filt == FLT_RSVD) |-> set_vec == '0);  // R5
endmodule

// File: rtl/sgi_clear_dec.sv
module sgi_clear_dec #(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int SGI_W  = $clog2(NUM_SGI),
  localparam int ROW_W  = NUM_CPU * NUM_CPU,
  localparam int PEND_W = NUM_SGI * ROW_W
) (
  input  logic              clr_valid,
  input  logic [SGI_W-1:0]  clr_sgi,
  input  logic [CPU_W-1:0]  clr_sender,
  input  logic [CPU_W-1:0]  clr_target,
  output logic [PEND_W-1:0] clr_vec
);
  for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
    for (genvar f = 0; f < NUM_CPU; f++) begin : g_from
      for (genvar t = 0; t < NUM_CPU; t++) begin : g_to
        assign clr_vec[s*ROW_W + f*NUM_CPU + t] = clr_valid &&
          clr_sgi == SGI_W'(s) && clr_sender == CPU_W'(f) && clr_target == CPU_W'(t);
      end
    end
  end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~pend_q) == '0));  // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));  // R8
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));  // R7
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));  // R8
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  parameter int WORD_W  = 32,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int SGI_W  = $clog2(NUM_SGI),
  localparam int ROW_W  = NUM_CPU * NUM_CPU,
  localparam int PEND_W = NUM_SGI * ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [CPU_W-1:0]   wr_sender,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NUM_CPU-1:0] cpu_en,
  input  logic               clr_valid,
  input  logic [SGI_W-1:0]   clr_sgi,
  input  logic [CPU_W-1:0]   clr_sender,
  input  logic [CPU_W-1:0]   clr_target,
  output logic [PEND_W-1:0]  pend_o
);
  logic              fire;
  logic [PEND_W-1:0] set_vec, clr_vec, win;

  assign wr_ready = rst_n;
  assign fire     = wr_valid && wr_ready;

  sgi_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sender(wr_sender),
    .data(wr_data), .cpu_en(cpu_en), .set_vec(set_vec)
  );

  sgi_clear_dec #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_clr (
    .clr_valid(clr_valid), .clr_sgi(clr_sgi), .clr_sender(clr_sender),
    .clr_target(clr_target), .clr_vec(clr_vec)
  );

  sgi_pend_bank #(.W(PEND_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend_q(pend_o)
  );

  // Row window of the current write, used only by the checks below.
  assign win = {{(PEND_W-NUM_CPU){1'b0}}, {NUM_CPU{1'b1}}}
               << (int'(wr_data[SGI_FLD_LSB +: SGI_W]) * ROW_W + int'(wr_sender) * NUM_CPU);

  AST_ROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~($past(fire) ? $past(win) : '0)) == '0));  // R7
  AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_data[FLT_FLD_LSB +: FLT_W] == FLT_RSVD && !clr_valid) |=> $stable(pend_o));  // R5
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !clr_valid) |=> $stable(pend_o));  // R1
endmodule

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [2:0]   wr_sender = '0;
  logic [31:0]  wr_data = '0;
  logic [7:0]   cpu_en = '0;
  logic         clr_valid = 1'b0;
  logic [3:0]   clr_sgi = '0;
  logic [2:0]   clr_sender = '0;
  logic [2:0]   clr_target = '0;
  logic [1023:0] pend_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sgi_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sender(wr_sender), .wr_data(wr_data), .cpu_en(cpu_en),
    .clr_valid(clr_valid), .clr_sgi(clr_sgi), .clr_sender(clr_sender),
    .clr_target(clr_target), .pend_o(pend_o)
  );

  // {req tag(4), sender(3), word(32), enables(8), expected row(64)}
  localparam logic [110:0] VEC [9] = '{
    {4'd2, 3'd2, 32'h00A5_0005, 8'hFF, 64'h0000_0000_00A5_0000},  // R2 list
    {4'd6, 3'd0, 32'h000F_0000, 8'h05, 64'h0000_0000_0000_0005},  // R6 disabled targets
    {4'd3, 3'd3, 32'h01FF_000F, 8'hFF, 64'h0000_0000_F700_0000},  // R3 all but sender
    {4'd3, 3'd7, 32'h0100_0003, 8'h7F, 64'h7F00_0000_0000_0000},  // R3 top sender
    {4'd4, 3'd4, 32'h0201_0009, 8'hFF, 64'h0000_0010_0000_0000},  // R4 self only
    {4'd6, 3'd4, 32'h0200_0009, 8'hEF, 64'h0000_0000_0000_0000},  // R6 self disabled
    {4'd5, 3'd1, 32'h03FF_0002, 8'hFF, 64'h0000_0000_0000_0000},  // R5 reserved filter
    {4'd2, 3'd6, 32'h0000_000C, 8'hFF, 64'h0000_0000_0000_0000},  // R2 empty list
    {4'd1, 3'd5, 32'hFCFF_FFF7, 8'h3C, 64'h0000_3C00_0000_0000}   // R1 junk in unused bits
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; clr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [63:0] row_of(input int s);
    return pend_o[s*64 +: 64];
  endfunction

  function automatic bit rest_zero(input int s);
    logic [1023:0] m;
    m = pend_o;
    m[s*64 +: 64] = '0;
    return m == '0;
  endfunction

  task automatic write1(input logic [2:0] snd, input logic [31:0] w, input logic [7:0] en);
    @(negedge clk);
    wr_valid = 1'b1; wr_sender = snd; wr_data = w; cpu_en = en;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    check(pend_o == '0, "R10 pend after reset", pend_o[63:0], 64'h0);
    check(wr_ready == 1'b1, "R10 ready", {63'h0, wr_ready}, 64'h1);

    // Table walk, fresh reset per vector
    for (int i = 0; i < 9; i++) begin
      logic [110:0] v;
      int s;
      v = VEC[i];
      s = int'(v[75:72]);
      do_reset();
      write1(v[106:104], v[103:72], v[71:64]);
      check(row_of(s) == v[63:0], $sformatf("R%0d vector %0d row", v[110:107], i), row_of(s), v[63:0]);
      check(rest_zero(s), $sformatf("R7 vector %0d other rows", i), 64'h0, 64'h0);
    end

    // R1: word presented without valid is not taken
    do_reset();
    @(negedge clk);
    wr_sender = 3'd1; wr_data = 32'h00FF_0004; cpu_en = 8'hFF;
    @(negedge clk);
    check(pend_o == '0, "R1 no valid no effect", pend_o[319:256], 64'h0);

    // R7: accumulation across senders in one slot
    write1(3'd1, 32'h0003_0004, 8'hFF);
    write1(3'd2, 32'h0004_0004, 8'hFF);
    check(row_of(4) == 64'h0004_0300, "R7 accumulate", row_of(4), 64'h0004_0300);

    // R8: single-bit clear
    @(negedge clk);
    clr_valid = 1'b1; clr_sgi = 4'd4; clr_sender = 3'd1; clr_target = 3'd0;
    @(negedge clk);
    clr_valid = 1'b0;
    check(row_of(4) == 64'h0004_0200, "R8 clear one bit", row_of(4), 64'h0004_0200);

    // R9: set and clear on the same bit
    @(negedge clk);
    wr_valid = 1'b1; wr_sender = 3'd1; wr_data = 32'h0002_0004; cpu_en = 8'hFF;
    clr_valid = 1'b1; clr_sgi = 4'd4; clr_sender = 3'd1; clr_target = 3'd1;
    @(negedge clk);
    wr_valid = 1'b0; clr_valid = 1'b0;
    check(row_of(4) == 64'h0004_0200, "R9 set wins", row_of(4), 64'h0004_0200);

    // R8: clear of that bit alone
    @(negedge clk);
    clr_valid = 1'b1; clr_sgi = 4'd4; clr_sender = 3'd1; clr_target = 3'd1;
    @(negedge clk);
    clr_valid = 1'b0;
    check(row_of(4) == 64'h0004_0000, "R8 clear second bit", row_of(4), 64'h0004_0000);
    check(rest_zero(4), "R8 other rows untouched", 64'h0, 64'h0);

    // R5: reserved filter leaves existing state alone
    write1(3'd2, 32'h03FF_0004, 8'hFF);
    check(row_of(4) == 64'h0004_0000, "R5 reserved keeps state", row_of(4), 64'h0004_0000);

    // R10: reset clears accumulated state
    do_reset();
    check(pend_o == '0, "R10 reset clears", pend_o[319:256], 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule